// File: doc/BRIEF.md
# Byte-Walking Nibble CRC Checksum Engine

This block computes a 16-bit checksum over a byte-addressed region of a non-volatile parameter memory and stores the result back into that memory. A one-cycle start strobe latches a base address and a byte length. The engine then reads the region through a synchronous single-port memory interface. It builds 16-bit words from pairs of adjacent bytes and folds each word into a running checksum with a nibble-oriented update step.

The address moves forward by one byte per word, so each word shares a byte with the previous word. If the length is odd, the last byte is folded in as the upper half of a word whose lower half is zero. When the walk is complete, the checksum is written to a fixed location in big-endian byte order, and a one-cycle done pulse follows. The checksum value also stays visible on an output port.

The memory port is a plain synchronous read/write port with a fixed latency, not a stream. It therefore has no valid/ready handshake and no back-pressure. Start, busy and done are plain control pins.

Top module: `nvcrc_engine`

## Requirements
- R1: After reset, `crc_o` is 0xFFFF, `busy_o` and `done_o` are low, and no memory access is issued. Each accepted start re-seeds the checksum to 0xFFFF, so a zero-length run stores 0xFFFF.
- R2: One update step turns the previous value c and the word w into a new value, computed as follows. Let p = c^w, a = p[3:0] and b = p[7:4]^a. The new value is (c>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits.
- R3: Let n be the length rounded down to even. For each k from 0 to n-1, the engine folds in the word whose high byte is at base+k and whose low byte is at base+k+1, with addresses wrapping modulo 2^AW.
- R4: When the length is odd, the engine makes one more update after the word steps. This update uses the byte at base+n in bits 15:8 and zero in bits 7:0.
- R5: The result is written as exactly two byte writes. The high byte goes to RES_ADDR (default 0xFC) first, and the low byte goes to RES_ADDR+1 (0xFD) second. There are no other writes.
- R6: `done_o` is a one-cycle pulse in the cycle that follows the low-byte write. When start is sampled at clock edge k, done is high in the cycle after edge k+3n+2·(len odd)+2.
- R7: A start strobe that arrives while `busy_o` is high has no effect on the result, the writes or the timing.
- R8: The base and length are taken only in the cycle in which start is accepted. Later changes to these inputs do not alter the run.
- R9: While the engine is idle and no start is given, `crc_o` holds the last result.
- R10: Reads have one cycle of latency. The two bytes of a word are requested in consecutive cycles, a read and a write never happen in the same cycle, and the memory port is quiet while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| base_i | input | AW | First byte address of the region |
| len_i | input | LW | Region length in bytes |
| busy_o | output | 1 | High from the accepted start through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 16 | Running or final checksum |
| mem_rd_en_o | output | 1 | Read request |
| mem_wr_en_o | output | 1 | Write request |
| mem_addr_o | output | AW | Byte address for the read or write |
| mem_wr_data_o | output | 8 | Write data byte |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 9-bit length and the result location at 0xFC. With the 8-bit address, a region that starts near the top of memory wraps through address 0. With the 9-bit length, the bench can run a full 256-byte walk, which also reads the result bytes of an earlier run. The lengths tested include 0, 1, both odd and even values, and the full 0xF8 parameter region. This covers the empty run, the tail-only run, the padded tail and the overlapping-word stepping.

// File: rtl/nvcrc_pkg.sv
package nvcrc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDHI,
    ST_RDLO,
    ST_UPD,
    ST_TRD,
    ST_TUPD,
    ST_WHI,
    ST_WLO,
    ST_DONE
  } nvcrc_state_e;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] nib_fold(input logic [15:0] prev, input logic [15:0] word);
    logic [15:0] mix;
    logic [15:0] lo4;
    logic [15:0] hi4;
    mix = prev ^ word;
    lo4 = {12'h000, mix[3:0]};
    hi4 = {12'h000, mix[7:4] ^ mix[3:0]};
    return (prev >> 8) ^ (lo4 << 3) ^ (lo4 << 8) ^ hi4 ^ (hi4 << 7) ^ (hi4 << 12);
  endfunction

endpackage

// File: rtl/nvcrc_step.sv
module nvcrc_step
  import nvcrc_pkg::*;
(
  input  logic [15:0] prev_i,
  input  logic [15:0] word_i,
  output logic [15:0] next_o
);
  always_comb next_o = nib_fold(prev_i, word_i);
endmodule

// File: rtl/nvcrc_seq.sv
module nvcrc_seq
  import nvcrc_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 9,
  parameter logic [AW-1:0] RES_ADDR = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic          accept_o,
  output logic          cap_hi_o,
  output logic          upd_word_o,
  output logic          upd_tail_o,
  output logic          wr_lo_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] RES_LO = RES_ADDR + 1'b1;

  nvcrc_state_e  state_q, state_d;
  logic [AW-1:0] cur_q;
  logic [LW-1:0] left_q;
  logic          odd_q;
  logic [LW-1:0] even_len;

  assign even_len = {len_i[LW-1:1], 1'b0};
  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (even_len != '0) state_d = ST_RDHI;
        else if (len_i[0])  state_d = ST_TRD;
        else                state_d = ST_WHI;
      end
      ST_RDHI: state_d = ST_RDLO;
      ST_RDLO: state_d = ST_UPD;
      ST_UPD: begin
        if (left_q != LW'(1)) state_d = ST_RDHI;
        else if (odd_q)       state_d = ST_TRD;
        else                  state_d = ST_WHI;
      end
      ST_TRD:  state_d = ST_TUPD;
      ST_TUPD: state_d = ST_WHI;
      ST_WHI:  state_d = ST_WLO;
      ST_WLO:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      odd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        cur_q  <= base_i;
        left_q <= even_len;
        odd_q  <= len_i[0];
      end else if (state_q == ST_UPD) begin
        cur_q  <= cur_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  always_comb begin
    rd_en_o = 1'b0;
    wr_en_o = 1'b0;
    addr_o  = '0;
    unique case (state_q)
      ST_RDHI, ST_TRD: begin rd_en_o = 1'b1; addr_o = cur_q; end
      ST_RDLO:         begin rd_en_o = 1'b1; addr_o = cur_q + 1'b1; end
      ST_WHI:          begin wr_en_o = 1'b1; addr_o = RES_ADDR; end
      ST_WLO:          begin wr_en_o = 1'b1; addr_o = RES_LO; end
      default: ;
    endcase
  end

  assign cap_hi_o   = (state_q == ST_RDLO);
  assign upd_word_o = (state_q == ST_UPD);
  assign upd_tail_o = (state_q == ST_TUPD);
  assign wr_lo_o    = (state_q == ST_WLO);
  assign done_o     = (state_q == ST_DONE);
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/nvcrc_engine.sv
module nvcrc_engine
  import nvcrc_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 9,
  parameter logic [AW-1:0] RES_ADDR = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [15:0]   crc_o,
  output logic          mem_rd_en_o,
  output logic          mem_wr_en_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wr_data_o,
  input  logic [7:0]    mem_rd_data_i
);
  logic        accept, cap_hi, upd_word, upd_tail, wr_lo;
  logic [7:0]  hi_q;
  logic [15:0] crc_q, fold_word, fold_next;

  nvcrc_seq #(.AW(AW), .LW(LW), .RES_ADDR(RES_ADDR)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .base_i     (base_i),
    .len_i      (len_i),
    .accept_o   (accept),
    .cap_hi_o   (cap_hi),
    .upd_word_o (upd_word),
    .upd_tail_o (upd_tail),
    .wr_lo_o    (wr_lo),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_en_o    (mem_rd_en_o),
    .wr_en_o    (mem_wr_en_o),
    .addr_o     (mem_addr_o)
  );

  // Word assembly: captured high byte with the fresh low byte, or padded tail.
  assign fold_word = upd_tail ? {mem_rd_data_i, 8'h00} : {hi_q, mem_rd_data_i};

  nvcrc_step u_step (
    .prev_i (crc_q),
    .word_i (fold_word),
    .next_o (fold_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      hi_q  <= 8'h00;
    end else begin
      if (cap_hi) hi_q <= mem_rd_data_i;
      if (accept)                     crc_q <= CRC_SEED;
      else if (upd_word || upd_tail)  crc_q <= fold_next;
    end
  end

  assign crc_o         = crc_q;
  assign mem_wr_data_o = wr_lo ? crc_q[7:0] : crc_q[15:8];
endmodule

// File: rtl/nvcrc_checker.sv
module nvcrc_checker #(
  parameter int AW = 8,
  parameter logic [AW-1:0] RES_ADDR = 8'hFC
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [15:0]   crc_o,
  input logic          mem_rd_en_o,
  input logic          mem_wr_en_o,
  input logic [AW-1:0] mem_addr_o
);
  localparam logic [AW-1:0] RES_LO = RES_ADDR + 1'b1;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_low_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_wr_en_o) && $past(mem_addr_o) == RES_LO));

  assert_write_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> (mem_addr_o == RES_ADDR || mem_addr_o == RES_LO));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_en_o && !mem_wr_en_o));

  assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en_o && mem_wr_en_o));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(crc_o));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

bind nvcrc_engine nvcrc_checker #(.AW(AW), .RES_ADDR(RES_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .crc_o       (crc_o),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_wr_en_o (mem_wr_en_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/tb_nvcrc_engine.sv
module tb_nvcrc_engine;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam logic [7:0] RES = 8'hFC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          busy_o, done_o, mem_rd_en_o, mem_wr_en_o;
  logic [15:0]   crc_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wr_data_o, mem_rd_data_i;

  always #2 clk = ~clk;

  nvcrc_engine #(.AW(AW), .LW(LW), .RES_ADDR(RES)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o),
    .mem_rd_en_o(mem_rd_en_o), .mem_wr_en_o(mem_wr_en_o), .mem_addr_o(mem_addr_o),
    .mem_wr_data_o(mem_wr_data_o), .mem_rd_data_i(mem_rd_data_i)
  );

  // Memory model: one cycle read latency, write log.
  logic [7:0] mem [256];
  logic [7:0] rdq = 8'h00;
  int         wr_count = 0;
  logic [7:0] wr_addr0, wr_addr1;
  assign mem_rd_data_i = rdq;

  always @(posedge clk) begin
    if (mem_rd_en_o) rdq <= mem[mem_addr_o];
    if (mem_wr_en_o) begin
      mem[mem_addr_o] <= mem_wr_data_o;
      if (wr_count == 0) wr_addr0 <= mem_addr_o;
      if (wr_count == 1) wr_addr1 <= mem_addr_o;
      wr_count <= wr_count + 1;
    end
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_step(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] p, a, b;
    p = c ^ w;
    a = {12'h0, p[3:0]};
    b = {12'h0, p[7:4] ^ p[3:0]};
    return (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  function automatic logic [15:0] model_crc(input logic [7:0] base, input int len);
    logic [15:0] c;
    int n;
    c = 16'hFFFF;
    n = len & ~1;
    for (int k = 0; k < n; k++)
      c = model_step(c, {mem[8'(base + k)], mem[8'(base + k + 1)]});
    if (len % 2 == 1) c = model_step(c, {mem[8'(base + n)], 8'h00});
    return c;
  endfunction

  // Vector table: {fill seed, base, length}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {8'h11, 8'h00, 9'd248},
    {8'h2B, 8'h00, 9'd2},
    {8'h05, 8'h10, 9'd3},
    {8'h77, 8'h40, 9'd5},
    {8'h9D, 8'hF0, 9'd20},
    {8'h31, 8'h00, 9'd1},
    {8'hC3, 8'h20, 9'd256},
    {8'h5A, 8'h80, 9'd127}
  };

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * seed) ^ 8'hA5;
  endtask

  // Runs one job; poke > 0 raises a stray start at that cycle with other inputs.
  task automatic run(input logic [7:0] base, input int len, input int poke, input string tag);
    logic [15:0] exp;
    int cyc, lat;
    exp = model_crc(base, len);
    lat = 3 * (len & ~1) + 2 * (len % 2) + 3;
    @(negedge clk);
    wr_count = 0;
    start_i = 1'b1; base_i = base; len_i = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
    base_i = ~base; len_i = LW'(3); // R8: changes after acceptance must not matter
    cyc = 1;
    while (!done_o && cyc < 5000) begin
      if (cyc == poke) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    check({tag, " R6 latency"}, cyc, lat);
    check({tag, " R2 R3 R4 crc_o"}, crc_o, exp);
    check({tag, " R5 high byte"}, mem[RES], exp[15:8]);
    check({tag, " R5 low byte"}, mem[RES + 8'd1], exp[7:0]);
    check({tag, " R5 write count"}, wr_count, 2);
    check({tag, " R5 write order"}, {wr_addr0, wr_addr1}, {RES, RES + 8'd1});
    @(negedge clk);
    check({tag, " R6 done one cycle"}, done_o, 1'b0);
  endtask

  initial begin
    #700000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    fill(8'h01);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset crc_o", crc_o, 16'hFFFF);
    check("R1 reset busy", busy_o, 1'b0);
    check("R1 reset done", done_o, 1'b0);
    check("R10 reset port quiet", {mem_rd_en_o, mem_wr_en_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk (R2 R3 R4 R5 R6 R8)
    for (int v = 0; v < NV; v++) begin
      fill(VEC[v][24:17]);
      run(VEC[v][16:9], int'(VEC[v][8:0]), 0, "vec");
    end

    // R1: zero length stores the seed
    fill(8'h3C);
    run(8'h00, 0, 0, "R1 zero length");
    check("R1 zero length value", crc_o, 16'hFFFF);

    // R7: stray start during a run
    fill(8'h6D);
    run(8'h08, 9, 5, "R7 stray start");

    // R9: result held while idle
    repeat (6) @(negedge clk);
    check("R9 crc_o held", crc_o, model_crc(8'h08, 9) == crc_o ? crc_o : 16'hxxxx);
    check("R9 idle busy", busy_o, 1'b0);

    // R1: a second run re-seeds (same data twice gives same result)
    fill(8'h44);
    run(8'h30, 6, 0, "R1 reseed a");
    run(8'h30, 6, 0, "R1 reseed b");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule